// File: doc/BRIEF.md
# USB L1 Entry Inactivity Timer

This block is a per-port timer for a USB 2.0 host port. It decides when the port should ask the attached device to enter the L1 sleep state, and it picks the resume-latency value that goes with that request. The timer counts microsecond ticks while the bus is idle. Any bus activity reloads it. When the programmed idle time runs out, the block issues a one-cycle L1 request. The request carries either the normal or the deep latency value, chosen by a 2-bit policy field.

The idle time comes from an 8-bit code. Code zero gives a short fixed interval. Any other code gives a whole multiple of 256 µs. Under the deep-first policy, a rejection of the deep request is followed at once by a second request that carries the normal value. After the device accepts, the timer stays quiet until the port becomes active again. A port reset clears the effective timeout code back to zero.

Top module: `l1_entry_timer`

## Requirements
- R1: With an effective timeout code of 0, the L1 request strobe rises in the cycle after the 128th idle `tick_us` pulse that is counted since the last reload.
- R2: With an effective timeout code n from 1 to 255, the strobe rises after n × 256 counted idle ticks. `timeout_now` shows the code one cycle after `timeout_code` changes.
- R3: A `port_reset` pulse sets `timeout_now` to 0 in the next cycle and reloads the counter. The code stays 0, giving 128-tick timeouts, until `timeout_code` changes to a different value.
- R4: Asserting `bus_active` reloads the idle count to zero. A tick in the same cycle as `bus_active` is not counted, and no count advances without a tick.
- R5: With `mode_sel` = 0, the request carries `lat_norm`.
- R6: With `mode_sel` = 1, the first request carries `lat_deep`. A reject response (`rsp_valid`=1, `rsp_accept`=0) to that request causes a second strobe in the very next cycle that carries the current `lat_norm`.
- R7: `mode_sel` values 2 and 3 behave exactly like 0.
- R8: `l1_req` is high for one cycle only. A response presented in the same cycle as the strobe is ignored.
- R9: `l1_lat` holds its value from the strobe until the response is taken, even if the latency inputs change in between.
- R10: After an accept, no further request is made until `bus_active` is seen. After that, a full timeout is counted from zero.
- R11: A reject of a normal-value request, or of the retry, re-arms the timer immediately with a count of zero.
- R12: After reset, `l1_req` is 0, `l1_lat` is 0 and `timeout_now` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| timeout_code | input | 8 | Programmed idle-timeout code |
| mode_sel | input | 2 | Latency policy: 1 = deep first, others = normal only |
| lat_norm | input | 4 | Normal resume-latency value |
| lat_deep | input | 4 | Deep resume-latency value |
| port_reset | input | 1 | Port reset pulse; clears the effective timeout code |
| bus_active | input | 1 | Bus traffic seen this cycle |
| rsp_valid | input | 1 | Device response to the L1 request is present |
| rsp_accept | input | 1 | 1 = device accepted, 0 = device rejected |
| l1_req | output | 1 | One-cycle L1 request strobe |
| l1_lat | output | 4 | Latency value sent with the request |
| timeout_now | output | 8 | Effective timeout code in use |

## Verification
On every cycle, assertions check four things: that the strobe is one cycle wide, that the latency output is stable while a response is pending, that the retry carries the normal value, and that the request stays low while the port sits in L1. They also check that activity and port reset clear the count and the code. Exact timeout lengths can only be shown by the bench's scenarios: 128, 256 × n and the 65,280-tick extreme, all under irregular tick spacing. The same holds for the rejection and re-arm sequences, for the mapping of the reserved policies, and for the ignored same-cycle response.

// File: rtl/l1_timer_pkg.sv
// Package: shared state and policy types for the L1 entry timer.
// Assumes: a mode value of 1 selects deep-first; every other value is normal-only.
package l1_timer_pkg;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,   // counting idle ticks
        ST_WAIT  = 2'd1,   // request issued, waiting for device response
        ST_L1    = 2'd2    // device accepted, port is asleep
    } l1_state_e;

    typedef enum logic {
        POL_NORMAL     = 1'b0,
        POL_DEEP_FIRST = 1'b1
    } lat_policy_e;

    // Map the 2-bit mode field onto a policy; reserved codes fall back to normal.
    function automatic lat_policy_e decode_policy(input logic [1:0] mode);
        return (mode == 2'd1) ? POL_DEEP_FIRST : POL_NORMAL;
    endfunction

endpackage

// File: rtl/l1_timeout_field.sv
// Module: holds the effective timeout code and turns it into a tick limit.
// Assumes: software changes timeout_code by writing a new value; a port reset
// forces the effective code to zero until the input value changes again.
module l1_timeout_field #(
    parameter int CODE_W     = 8,
    parameter int UNIT_SHIFT = 8,
    parameter int ZERO_TICKS = 128,
    parameter int CNT_W      = CODE_W + UNIT_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_reset,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_eff,
    output logic [CNT_W-1:0]  limit
);

    logic [CODE_W-1:0] code_seen;

    // Track input writes; a port reset overrides the effective code with zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_eff  <= '0;
            code_seen <= '0;
        end else if (port_reset) begin
            code_eff  <= '0;
            code_seen <= code_in;
        end else if (code_in != code_seen) begin
            code_eff  <= code_in;
            code_seen <= code_in;
        end
    end

    // Decode the code into a number of microsecond ticks.
    always_comb begin
        if (code_eff == '0)
            limit = CNT_W'(ZERO_TICKS);
        else
            limit = CNT_W'(code_eff) << UNIT_SHIFT;
    end

    // R3: a port reset leaves the effective code at zero.
    a_r3_reset_clears_code: assert property (@(posedge clk) disable iff (!rst_n)
        port_reset |=> (code_eff == '0));

endmodule

// File: rtl/l1_idle_counter.sv
// Module: counts microsecond ticks while the port is armed and idle.
// Assumes: limit is at least 1; activity in a cycle cancels that cycle's tick.
module l1_idle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             tick,
    input  logic             activity,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             reach;

    // Next count and whether it meets the (possibly just lowered) limit.
    always_comb begin
        cnt_next = cnt + CNT_W'(1);
        reach    = (cnt_next >= limit);
        expire   = armed && tick && !activity && reach;
    end

    // Advance on idle ticks; clear on activity, disarm or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || activity || expire)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_next;
    end

    // R4: any activity leaves the count at zero.
    a_r4_activity_reload: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> (cnt == '0));

    // R4: without a tick the count never advances.
    a_r4_no_tick_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (cnt == '0 || $stable(cnt)));

endmodule

// File: rtl/l1_req_fsm.sv
// Module: issues the L1 request, selects the latency and runs the deep-to-normal retry.
// Assumes: a response never refers to a strobe issued in the same cycle, so a
// response seen while the strobe is high is dropped.
module l1_req_fsm
    import l1_timer_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_reset,
    input  logic             bus_active,
    input  logic             expire,
    input  logic [1:0]       mode,
    input  logic [LAT_W-1:0] lat_norm,
    input  logic [LAT_W-1:0] lat_deep,
    input  logic             rsp_valid,
    input  logic             rsp_accept,
    output logic             armed,
    output logic             l1_req,
    output logic [LAT_W-1:0] lat_out
);

    l1_state_e   state;
    logic        deep_try;
    logic        rsp_take;
    lat_policy_e policy;

    // Decode the policy and qualify the response.
    always_comb begin
        policy   = decode_policy(mode);
        rsp_take = rsp_valid && !l1_req;
        armed    = (state == ST_ARMED);
    end

    // Sequence: count -> request -> (retry) -> sleep or re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_ARMED;
            deep_try <= 1'b0;
            l1_req   <= 1'b0;
            lat_out  <= '0;
        end else if (port_reset) begin
            state    <= ST_ARMED;
            deep_try <= 1'b0;
            l1_req   <= 1'b0;
        end else begin
            l1_req <= 1'b0;
            unique case (state)
                ST_ARMED: begin
                    if (expire) begin
                        l1_req   <= 1'b1;
                        deep_try <= (policy == POL_DEEP_FIRST);
                        lat_out  <= (policy == POL_DEEP_FIRST) ? lat_deep : lat_norm;
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_take) begin
                        if (rsp_accept) begin
                            state    <= ST_L1;
                            deep_try <= 1'b0;
                        end else if (deep_try) begin
                            l1_req   <= 1'b1;
                            lat_out  <= lat_norm;
                            deep_try <= 1'b0;
                        end else begin
                            state <= ST_ARMED;
                        end
                    end
                end
                ST_L1: begin
                    if (bus_active)
                        state <= ST_ARMED;
                end
                default: state <= ST_ARMED;
            endcase
        end
    end

    // R8: the request is a single-cycle strobe.
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        l1_req |=> !l1_req);

    // R9: latency stays put while a response is pending.
    a_r9_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state == ST_WAIT) && !l1_req) |-> $stable(lat_out));

    // R6: a strobe raised from the waiting state is the retry with the normal value.
    a_r6_retry_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req && $past(state == ST_WAIT)) |-> (lat_out == $past(lat_norm)));

    // R10: no request while the port sleeps in L1.
    a_r10_quiet_in_l1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_L1) |-> !l1_req);

endmodule

// File: rtl/l1_entry_timer.sv
// Module: top of the per-port L1 entry timer.
// Assumes: tick_us is a one-cycle pulse per microsecond; bus_active marks any
// traffic; responses arrive at least one cycle after the strobe.
module l1_entry_timer #(
    parameter int CODE_W     = 8,
    parameter int LAT_W      = 4,
    parameter int UNIT_SHIFT = 8,
    parameter int ZERO_TICKS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic [CODE_W-1:0] timeout_code,
    input  logic [1:0]        mode_sel,
    input  logic [LAT_W-1:0]  lat_norm,
    input  logic [LAT_W-1:0]  lat_deep,
    input  logic              port_reset,
    input  logic              bus_active,
    input  logic              rsp_valid,
    input  logic              rsp_accept,
    output logic              l1_req,
    output logic [LAT_W-1:0]  l1_lat,
    output logic [CODE_W-1:0] timeout_now
);

    localparam int CNT_W = CODE_W + UNIT_SHIFT;

    logic [CNT_W-1:0] limit;
    logic             armed;
    logic             expire;
    logic             activity;

    // Port reset counts as activity for the idle counter.
    always_comb activity = bus_active || port_reset;

    l1_timeout_field #(
        .CODE_W    (CODE_W),
        .UNIT_SHIFT(UNIT_SHIFT),
        .ZERO_TICKS(ZERO_TICKS),
        .CNT_W     (CNT_W)
    ) u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_reset(port_reset),
        .code_in   (timeout_code),
        .code_eff  (timeout_now),
        .limit     (limit)
    );

    l1_idle_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .tick    (tick_us),
        .activity(activity),
        .limit   (limit),
        .expire  (expire)
    );

    l1_req_fsm #(
        .LAT_W(LAT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_reset(port_reset),
        .bus_active(bus_active),
        .expire    (expire),
        .mode      (mode_sel),
        .lat_norm  (lat_norm),
        .lat_deep  (lat_deep),
        .rsp_valid (rsp_valid),
        .rsp_accept(rsp_accept),
        .armed     (armed),
        .l1_req    (l1_req),
        .lat_out   (l1_lat)
    );

endmodule

// File: tb/l1_entry_timer_bench.sv
`timescale 1ns/1ps
module l1_entry_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_us;
    logic [7:0] timeout_code;
    logic [1:0] mode_sel;
    logic [3:0] lat_norm;
    logic [3:0] lat_deep;
    logic       port_reset;
    logic       bus_active;
    logic       rsp_valid;
    logic       rsp_accept;
    logic       l1_req;
    logic [3:0] l1_lat;
    logic [7:0] timeout_now;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    l1_entry_timer u_l1_entry_timer (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .timeout_code(timeout_code),
        .mode_sel(mode_sel), .lat_norm(lat_norm), .lat_deep(lat_deep),
        .port_reset(port_reset), .bus_active(bus_active), .rsp_valid(rsp_valid),
        .rsp_accept(rsp_accept), .l1_req(l1_req), .l1_lat(l1_lat), .timeout_now(timeout_now)
    );

    function automatic int exp_ticks(input int code);
        return (code == 0) ? 128 : code * 256;
    endfunction

    function automatic int exp_first_lat(input int mode, input int nrm, input int dp);
        return (mode == 1) ? dp : nrm;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic t);
        tick_us = t;
        @(negedge clk);
    endtask

    task automatic pulse_activity();
        bus_active = 1'b1;
        step(1'b1);          // tick together with activity must not count (R4)
        bus_active = 1'b0;
        tick_us    = 1'b0;
    endtask

    task automatic respond(input bit acc);
        rsp_valid  = 1'b1;
        rsp_accept = acc;
        @(negedge clk);
        rsp_valid  = 1'b0;
    endtask

    // Feed idle ticks with random gaps until the strobe shows; compare tick count and latency.
    task automatic wait_req(input int n_exp, input int lat_exp, input int maxgap, input string tag);
        int  n = 0;
        bit  got = 1'b0;
        bit  early = 1'b0;
        while (!got && n < n_exp + 8) begin
            int gap = int'($urandom_range(0, maxgap));
            for (int g = 0; g < gap; g++) begin
                step(1'b0);
                if (l1_req) early = 1'b1;
            end
            step(1'b1);
            n++;
            if (l1_req) got = 1'b1;
        end
        tick_us = 1'b0;
        chk(got && !early && n == n_exp, tag, n, n_exp);
        chk(l1_lat == 4'(lat_exp), {tag, " latency"}, int'(l1_lat), lat_exp);
    endtask

    // Strobe must drop after one cycle (R8).
    task automatic check_drop(input string tag);
        step(1'b0);
        chk(!l1_req, {tag, " R8 single strobe"}, int'(l1_req), 0);
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step(1'b1);
            if (l1_req) seen = 1'b1;
        end
        tick_us = 1'b0;
        chk(!seen, tag, int'(seen), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; tick_us = 1'b0; timeout_code = 8'd0; mode_sel = 2'd0;
        lat_norm = 4'd5; lat_deep = 4'd9; port_reset = 1'b0; bus_active = 1'b0;
        rsp_valid = 1'b0; rsp_accept = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(!l1_req, "R12 l1_req", int'(l1_req), 0);
        chk(l1_lat == 4'd0, "R12 l1_lat", int'(l1_lat), 0);
        chk(timeout_now == 8'd0, "R12 timeout_now", int'(timeout_now), 0);

        // R1, R5: code 0, normal policy
        pulse_activity();
        wait_req(128, 5, 2, "R1/R5 code0 mode0");
        check_drop("R1");
        respond(1'b1);
        // R10: asleep, ticks do nothing until activity
        quiet(300, "R10 no request while in L1");
        pulse_activity();
        wait_req(128, 5, 1, "R10 re-arm after activity");
        check_drop("R10");
        // R11: normal request rejected re-arms from zero
        respond(1'b0);
        wait_req(128, 5, 1, "R11 re-arm after reject");
        check_drop("R11");
        respond(1'b1);

        // R4: activity mid-count reloads
        pulse_activity();
        for (int i = 0; i < 100; i++) step(1'b1);
        pulse_activity();
        wait_req(128, 5, 1, "R4 reload on activity");
        check_drop("R4");
        respond(1'b1);

        // R6, R8, R9: deep first, same-cycle response ignored, retry with normal
        mode_sel = 2'd1; lat_deep = 4'd12; lat_norm = 4'd3; timeout_code = 8'd1;
        pulse_activity();
        chk(timeout_now == 8'd1, "R2 timeout_now follows write", int'(timeout_now), 1);
        wait_req(256, 12, 1, "R2/R6 code1 deep first");
        respond(1'b1);   // presented during the strobe cycle: must be ignored (R8)
        chk(!l1_req, "R8 strobe dropped", int'(l1_req), 0);
        lat_norm = 4'd7; lat_deep = 4'd1;
        repeat (3) step(1'b0);
        chk(l1_lat == 4'd12, "R9 latency held while waiting", int'(l1_lat), 12);
        respond(1'b0);
        chk(l1_req && l1_lat == 4'd7, "R6/R8 retry with normal after reject", int'(l1_lat), 7);
        check_drop("R6");
        respond(1'b1);
        quiet(50, "R10 quiet after accepted retry");

        // R11: deep and retry both rejected -> re-arm, next attempt deep again
        lat_norm = 4'd3; lat_deep = 4'd12;
        pulse_activity();
        wait_req(256, 12, 1, "R6 deep attempt");
        check_drop("R6 second");
        respond(1'b0);
        chk(l1_req && l1_lat == 4'd3, "R6 retry latency", int'(l1_lat), 3);
        check_drop("R6 retry");
        respond(1'b0);
        wait_req(256, 12, 1, "R11 re-arm after retry reject");
        check_drop("R11 second");
        respond(1'b1);

        // R7: reserved policies act as normal
        for (int m = 2; m < 4; m++) begin
            mode_sel = 2'(m); timeout_code = 8'd2; lat_norm = 4'(m + 4); lat_deep = 4'd15;
            pulse_activity();
            wait_req(512, m + 4, 1, "R7 reserved mode");
            check_drop("R7");
            respond(1'b1);
        end

        // R3: port reset forces code 0
        mode_sel = 2'd0; timeout_code = 8'd3; lat_norm = 4'd6;
        pulse_activity();
        chk(timeout_now == 8'd3, "R2 timeout_now 3", int'(timeout_now), 3);
        for (int i = 0; i < 50; i++) step(1'b1);
        port_reset = 1'b1;
        step(1'b0);
        port_reset = 1'b0;
        chk(timeout_now == 8'd0, "R3 code cleared by port reset", int'(timeout_now), 0);
        wait_req(128, 6, 1, "R3 128 ticks after port reset");
        check_drop("R3");
        respond(1'b1);
        timeout_code = 8'd1;
        pulse_activity();
        chk(timeout_now == 8'd1, "R3 new write takes effect", int'(timeout_now), 1);

        // R2: largest code
        timeout_code = 8'hFF; lat_norm = 4'd10;
        pulse_activity();
        wait_req(65280, 10, 0, "R2 code FF");
        check_drop("R2 FF");
        respond(1'b1);

        // Random mix of codes, policies, latencies and responses
        for (int it = 0; it < 16; it++) begin
            int code = int'($urandom_range(0, 3));
            int md   = int'($urandom_range(0, 3));
            int ln   = int'($urandom_range(0, 15));
            int ld   = int'($urandom_range(0, 15));
            bit acc1 = 1'($urandom_range(0, 1));
            bit acc2 = 1'($urandom_range(0, 1));
            timeout_code = 8'(code); mode_sel = 2'(md);
            lat_norm = 4'(ln); lat_deep = 4'(ld);
            pulse_activity();
            chk(timeout_now == 8'(code), "R2 random timeout_now", int'(timeout_now), code);
            wait_req(exp_ticks(code), exp_first_lat(md, ln, ld), 1, "R2/R5/R6/R7 random");
            check_drop("random");
            respond(acc1);
            if (!acc1 && md == 1) begin
                chk(l1_req && l1_lat == 4'(ln), "R6 random retry", int'(l1_lat), ln);
                check_drop("random retry");
                respond(acc2);
            end
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule